// File: doc/BRIEF.md
# Banked Context Identifier Register with Privilege-Checked Access

This block holds the 32-bit context identifier that names the running process, in a secure copy and a non-secure copy. Software reaches it through a coprocessor-style register port. Each request on that port carries:

- a read/write flag and write data;
- the five-field encoding tuple;
- the current privilege level (0 to 3);
- the hypervisor trap controls and the monitor's NS bit.

In the same cycle the block answers with read data, an undefined-instruction flag or a hypervisor trap with its syndrome class. A granted write lands on the next clock edge.

The resolution runs as a fixed priority chain. Level 0 is always refused. At level 1 the CRn-13 trap is checked first and the virtual-memory trap second. The virtual-memory check looks at a read-side control for reads and a write-side control for writes. Levels 1 and 2 reach the non-secure copy. When no 32-bit monitor exists, that same storage acts as the single unbanked register. Level 3 picks the copy from the monitor's NS bit.

A debug/trace view is exported continuously. It shows the copy that matches the current security state, split into a process identifier and an address-space identifier when the short-descriptor format is active.

Top module: `ctxid_access`

## Requirements
- R1: An access is claimed (acc_hit=1) only for the tuple coprocessor=15, opc1=0, CRn=13, CRm=0, opc2=1. Any other tuple leaves acc_hit, acc_undef, acc_trap and acc_rdata at 0 and writes nothing.
- R2: A claimed access at privilege level 0 sets acc_undef=1, with acc_trap=0, acc_rdata=0 and no write.
- R3: A claimed level-1 access with el2_enabled=1 and hyp_trap_crn13=1 sets acc_trap=1 and acc_syndrome=6'h03 and writes nothing, whatever the virtual-memory trap bits are.
- R4: When the CRn-13 trap does not apply, a claimed level-1 access with el2_enabled=1 traps as follows: a read traps when hyp_trap_vm_rd=1 and ignores hyp_trap_vm_wr; a write traps when hyp_trap_vm_wr=1 and ignores hyp_trap_vm_rd.
- R5: With el2_enabled=0 no access traps. During a trap, acc_trap_el2_32 equals el2_is_32bit. Outside a trap, acc_trap_el2_32 and acc_syndrome are 0.
- R6: Granted accesses at levels 1 and 2 read and write the non-secure copy, whatever the monitor configuration.
- R7: At level 3, mon_ns_bit=0 selects the secure copy and mon_ns_bit=1 selects the non-secure copy.
- R8: Read data appears combinationally in the cycle of the strobe. A granted write changes the stored copy on the next rising clock edge, and not before.
- R9: After reset the secure copy holds parameter RST_SECURE and the non-secure copy holds RST_NONSECURE. The defaults are the nonzero values 32'hA5C3_0F1E and 32'h5A3C_F0E1.
- R10: dbg_ctx shows the secure copy when el3_present, el3_is_32bit and cur_secure are all 1, and the non-secure copy otherwise. It follows a write to that copy one cycle later.
- R11: With long_desc_mode=0, dbg_proc_id is dbg_ctx[31:8] zero-extended, dbg_asid is dbg_ctx[7:0] and dbg_asid_valid=1. With long_desc_mode=1, dbg_proc_id is dbg_ctx, dbg_asid=0 and dbg_asid_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_coproc | input | 4 | Coprocessor number of the access |
| acc_opc1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_opc2 | input | 3 | Second opcode field |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 2 | Current privilege level |
| el2_enabled | input | 1 | Hypervisor level is enabled |
| el2_is_32bit | input | 1 | Hypervisor level runs in 32-bit state |
| el3_present | input | 1 | Monitor level exists |
| el3_is_32bit | input | 1 | Monitor level runs in 32-bit state |
| hyp_trap_crn13 | input | 1 | Hypervisor trap for CRn 13 accesses |
| hyp_trap_vm_rd | input | 1 | Hypervisor trap for virtual-memory register reads |
| hyp_trap_vm_wr | input | 1 | Hypervisor trap for virtual-memory register writes |
| mon_ns_bit | input | 1 | Monitor NS bit for level-3 bank choice |
| long_desc_mode | input | 1 | Long-descriptor translation format active |
| cur_secure | input | 1 | Current security state is secure |
| acc_hit | output | 1 | Access tuple claimed by this block |
| acc_rdata | output | 32 | Read data of a granted read |
| acc_undef | output | 1 | Undefined-instruction indication |
| acc_trap | output | 1 | Hypervisor trap indication |
| acc_trap_el2_32 | output | 1 | Trap goes to a 32-bit hypervisor |
| acc_syndrome | output | 6 | Trap syndrome class |
| dbg_ctx | output | 32 | Live context identifier for debug and trace |
| dbg_proc_id | output | 32 | Process identifier field of the view |
| dbg_asid | output | 8 | Address-space identifier field of the view |
| dbg_asid_valid | output | 1 | Address-space identifier field is present |

## Verification
The bench sweeps every combination of privilege level, direction, hypervisor enable and state, the three trap bits, the monitor NS bit and the monitor configuration. A design that reversed the two virtual-memory controls, or checked them before the CRn-13 trap, would grant or trap the wrong access. It would also let a trapped write through and corrupt the copy seen later. A bank choice made from the security state rather than from the privilege level would write the secure copy from level 1. Mistuple accesses and a write observed before its edge are also checked, so a loose decoder or a combinational write path would show up on the debug view.

// File: rtl/ctxid_pkg.sv
package ctxid_pkg;

  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_GRANT = 2'd1,
    OUT_UNDEF = 2'd2,
    OUT_TRAP  = 2'd3
  } outcome_e;

  typedef enum logic {
    BANK_NS = 1'b0,
    BANK_S  = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;
  localparam int PRIV_W    = 2;

endpackage

// File: rtl/ctxid_rst_sync.sv
module ctxid_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ctxid_decode.sv
module ctxid_decode #(
  parameter logic [3:0] MATCH_COPROC = 4'd15,
  parameter logic [2:0] MATCH_OPC1   = 3'd0,
  parameter logic [3:0] MATCH_CRN    = 4'd13,
  parameter logic [3:0] MATCH_CRM    = 4'd0,
  parameter logic [2:0] MATCH_OPC2   = 3'd1
) (
  input  logic [3:0] coproc,
  input  logic [2:0] opc1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] opc2,
  output logic       hit
);

  localparam int NFIELD = 5;

  logic [NFIELD-1:0] field_ok;

  always_comb begin
    field_ok[0] = (coproc == MATCH_COPROC);
    field_ok[1] = (opc1   == MATCH_OPC1);
    field_ok[2] = (crn    == MATCH_CRN);
    field_ok[3] = (crm    == MATCH_CRM);
    field_ok[4] = (opc2   == MATCH_OPC2);
    hit         = &field_ok;
  end

endmodule

// File: rtl/ctxid_resolve.sv
module ctxid_resolve
  import ctxid_pkg::*;
(
  input  logic              valid,
  input  logic              hit,
  input  logic              write,
  input  logic [PRIV_W-1:0] priv,
  input  logic              el2_enabled,
  input  logic              trap_crn13,
  input  logic              trap_vm_rd,
  input  logic              trap_vm_wr,
  input  logic              mon_ns,
  output outcome_e          outcome,
  output bank_e             bank
);

  logic vm_trap_sel;

  always_comb begin
    vm_trap_sel = write ? trap_vm_wr : trap_vm_rd;
    outcome     = OUT_NONE;
    bank        = BANK_NS;
    if (valid && hit) begin
      unique case (priv)
        2'd0: outcome = OUT_UNDEF;
        2'd1: begin
          if (el2_enabled && trap_crn13) begin
            outcome = OUT_TRAP;
          end else if (el2_enabled && vm_trap_sel) begin
            outcome = OUT_TRAP;
          end else begin
            outcome = OUT_GRANT;
          end
        end
        2'd2: outcome = OUT_GRANT;
        default: begin
          outcome = OUT_GRANT;
          bank    = mon_ns ? BANK_NS : BANK_S;
        end
      endcase
    end
  end

endmodule

// File: rtl/ctxid_store.sv
module ctxid_store
  import ctxid_pkg::*;
#(
  parameter int                DATA_W        = 32,
  parameter logic [DATA_W-1:0] RST_SECURE    = 32'hA5C3_0F1E,
  parameter logic [DATA_W-1:0] RST_NONSECURE = 32'h5A3C_F0E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_e             wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  bank_e             rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  bank_e             view_sel,
  output logic [DATA_W-1:0] view_data
);

  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_d;
  logic [NUM_BANKS-1:0]             bank_ce;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [DATA_W-1:0] RST_VAL =
      (b == int'(BANK_S)) ? RST_SECURE : RST_NONSECURE;

    always_comb begin
      bank_ce[b] = wr_en && (wr_sel == bank_e'(b));
      bank_d[b]  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[b] <= RST_VAL;
      end else if (bank_ce[b]) begin
        bank_q[b] <= bank_d[b];
      end
    end
  end

  assign rd_data   = bank_q[rd_sel];
  assign view_data = bank_q[view_sel];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q[$past(wr_sel)] == $past(wr_data))) else $error("write lost"); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(bank_q[0]) && $stable(bank_q[1]))) else $error("bank changed"); // R8

  AST_OTHER_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == BANK_NS) |=> $stable(bank_q[BANK_S])) else $error("secure bank hit"); // R6

endmodule

// File: rtl/ctxid_view.sv
module ctxid_view #(
  parameter int DATA_W = 32,
  parameter int ASID_W = 8
) (
  input  logic              long_desc,
  input  logic [DATA_W-1:0] ctx,
  output logic [DATA_W-1:0] proc_id,
  output logic [ASID_W-1:0] asid,
  output logic              asid_valid
);

  localparam int SHORT_PROC_W = DATA_W - ASID_W;

  always_comb begin
    if (long_desc) begin
      proc_id    = ctx;
      asid       = '0;
      asid_valid = 1'b0;
    end else begin
      proc_id    = {{ASID_W{1'b0}}, ctx[DATA_W-1:ASID_W]};
      asid       = ctx[ASID_W-1:0];
      asid_valid = 1'b1;
    end
  end

  initial begin
    AST_SPLIT_FITS: assert (SHORT_PROC_W > 0) else $error("bad split"); // R11
  end

endmodule

// File: rtl/ctxid_access.sv
module ctxid_access
  import ctxid_pkg::*;
#(
  parameter int                DATA_W        = 32,
  parameter int                ASID_W        = 8,
  parameter int                SYND_W        = 6,
  parameter logic [SYND_W-1:0] TRAP_CLASS    = 6'h03,
  parameter logic [DATA_W-1:0] RST_SECURE    = 32'hA5C3_0F1E,
  parameter logic [DATA_W-1:0] RST_NONSECURE = 32'h5A3C_F0E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [3:0]        acc_coproc,
  input  logic [2:0]        acc_opc1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_opc2,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [1:0]        acc_priv,
  input  logic              el2_enabled,
  input  logic              el2_is_32bit,
  input  logic              el3_present,
  input  logic              el3_is_32bit,
  input  logic              hyp_trap_crn13,
  input  logic              hyp_trap_vm_rd,
  input  logic              hyp_trap_vm_wr,
  input  logic              mon_ns_bit,
  input  logic              long_desc_mode,
  input  logic              cur_secure,
  output logic              acc_hit,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_undef,
  output logic              acc_trap,
  output logic              acc_trap_el2_32,
  output logic [SYND_W-1:0] acc_syndrome,
  output logic [DATA_W-1:0] dbg_ctx,
  output logic [DATA_W-1:0] dbg_proc_id,
  output logic [ASID_W-1:0] dbg_asid,
  output logic              dbg_asid_valid
);

  logic              rst_sync_n;
  logic              tuple_hit;
  outcome_e          outcome;
  bank_e             acc_bank;
  bank_e             view_bank;
  logic              wr_en;
  logic [DATA_W-1:0] bank_rd;

  ctxid_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctxid_decode u_dec (
    .coproc (acc_coproc),
    .opc1   (acc_opc1),
    .crn    (acc_crn),
    .crm    (acc_crm),
    .opc2   (acc_opc2),
    .hit    (tuple_hit)
  );

  ctxid_resolve u_res (
    .valid       (acc_valid),
    .hit         (tuple_hit),
    .write       (acc_write),
    .priv        (acc_priv),
    .el2_enabled (el2_enabled),
    .trap_crn13  (hyp_trap_crn13),
    .trap_vm_rd  (hyp_trap_vm_rd),
    .trap_vm_wr  (hyp_trap_vm_wr),
    .mon_ns      (mon_ns_bit),
    .outcome     (outcome),
    .bank        (acc_bank)
  );

  always_comb begin
    view_bank = (el3_present && el3_is_32bit && cur_secure) ? BANK_S : BANK_NS;
    wr_en     = (outcome == OUT_GRANT) && acc_write;
  end

  ctxid_store #(
    .DATA_W        (DATA_W),
    .RST_SECURE    (RST_SECURE),
    .RST_NONSECURE (RST_NONSECURE)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_sel    (acc_bank),
    .wr_data   (acc_wdata),
    .rd_sel    (acc_bank),
    .rd_data   (bank_rd),
    .view_sel  (view_bank),
    .view_data (dbg_ctx)
  );

  ctxid_view #(.DATA_W(DATA_W), .ASID_W(ASID_W)) u_view (
    .long_desc  (long_desc_mode),
    .ctx        (dbg_ctx),
    .proc_id    (dbg_proc_id),
    .asid       (dbg_asid),
    .asid_valid (dbg_asid_valid)
  );

  always_comb begin
    acc_hit         = acc_valid && tuple_hit;
    acc_undef       = (outcome == OUT_UNDEF);
    acc_trap        = (outcome == OUT_TRAP);
    acc_trap_el2_32 = acc_trap && el2_is_32bit;
    acc_syndrome    = acc_trap ? TRAP_CLASS : '0;
    acc_rdata       = ((outcome == OUT_GRANT) && !acc_write) ? bank_rd : '0;
  end

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_hit |-> (!acc_undef && !acc_trap && acc_rdata == '0)) else $error("miss answered"); // R1

  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_hit && acc_priv == 2'd0) |-> (acc_undef && !acc_trap && !wr_en)) else $error("level 0 served"); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({acc_undef, acc_trap, wr_en})) else $error("mixed outcome"); // R3

  AST_NO_TRAP_EL2_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !el2_enabled |-> !acc_trap) else $error("trap with level 2 off"); // R5

  AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_trap |-> (acc_syndrome == TRAP_CLASS)) else $error("bad syndrome"); // R3

  AST_L3_SECURE_BANK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && acc_priv == 2'd3 && !mon_ns_bit) |-> (acc_bank == BANK_S)) else $error("bank choice"); // R7

  AST_LOW_PRIV_NS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && acc_priv != 2'd3) |-> (acc_bank == BANK_NS)) else $error("low level bank"); // R6

endmodule

// File: tb/ctxid_access_test.sv
module ctxid_access_test;

  localparam logic [31:0] RS  = 32'hA5C3_0F1E;
  localparam logic [31:0] RNS = 32'h5A3C_F0E1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [3:0]  acc_coproc, acc_crn, acc_crm;
  logic [2:0]  acc_opc1, acc_opc2;
  logic [31:0] acc_wdata;
  logic [1:0]  acc_priv;
  logic        el2_enabled, el2_is_32bit, el3_present, el3_is_32bit;
  logic        hyp_trap_crn13, hyp_trap_vm_rd, hyp_trap_vm_wr;
  logic        mon_ns_bit, long_desc_mode, cur_secure;
  logic        acc_hit, acc_undef, acc_trap, acc_trap_el2_32;
  logic [31:0] acc_rdata, dbg_ctx, dbg_proc_id;
  logic [5:0]  acc_syndrome;
  logic [7:0]  dbg_asid;
  logic        dbg_asid_valid;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m_s, m_ns;

  always #10 clk = ~clk;

  ctxid_access uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_coproc(acc_coproc), .acc_opc1(acc_opc1), .acc_crn(acc_crn),
    .acc_crm(acc_crm), .acc_opc2(acc_opc2), .acc_wdata(acc_wdata),
    .acc_priv(acc_priv), .el2_enabled(el2_enabled), .el2_is_32bit(el2_is_32bit),
    .el3_present(el3_present), .el3_is_32bit(el3_is_32bit),
    .hyp_trap_crn13(hyp_trap_crn13), .hyp_trap_vm_rd(hyp_trap_vm_rd),
    .hyp_trap_vm_wr(hyp_trap_vm_wr), .mon_ns_bit(mon_ns_bit),
    .long_desc_mode(long_desc_mode), .cur_secure(cur_secure),
    .acc_hit(acc_hit), .acc_rdata(acc_rdata), .acc_undef(acc_undef),
    .acc_trap(acc_trap), .acc_trap_el2_32(acc_trap_el2_32),
    .acc_syndrome(acc_syndrome), .dbg_ctx(dbg_ctx), .dbg_proc_id(dbg_proc_id),
    .dbg_asid(dbg_asid), .dbg_asid_valid(dbg_asid_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic set_tuple(input logic [3:0] cp, input logic [2:0] o1,
                           input logic [3:0] cn, input logic [3:0] cm,
                           input logic [2:0] o2);
    acc_coproc = cp; acc_opc1 = o1; acc_crn = cn; acc_crm = cm; acc_opc2 = o2;
  endtask

  function automatic logic [31:0] view_exp(input logic cs);
    return (el3_present && el3_is_32bit && cs) ? m_s : m_ns;
  endfunction

  // level-3 access to a chosen bank, one clock; checks R7 routing
  task automatic l3_access(input logic wr, input logic ns, input logic [31:0] d);
    @(negedge clk);
    set_tuple(4'd15, 3'd0, 4'd13, 4'd0, 3'd1);
    acc_valid = 1'b1; acc_write = wr; acc_priv = 2'd3; mon_ns_bit = ns; acc_wdata = d;
    #2;
    if (!wr) chk("R7 level-3 read bank", acc_rdata, ns ? m_ns : m_s);
    @(posedge clk);
    if (wr) begin
      if (ns) m_ns = d; else m_s = d;
    end
    #2 acc_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0; acc_priv = '0;
    set_tuple(4'd15, 3'd0, 4'd13, 4'd0, 3'd1);
    el2_enabled = 0; el2_is_32bit = 0; el3_present = 1; el3_is_32bit = 1;
    hyp_trap_crn13 = 0; hyp_trap_vm_rd = 0; hyp_trap_vm_wr = 0;
    mon_ns_bit = 0; long_desc_mode = 0; cur_secure = 0;
    m_s = RS; m_ns = RNS;
    repeat (4) @(posedge clk);
    #2;
    // R9 reset state through the debug view
    chk("R9 reset non-secure copy", dbg_ctx, RNS);
    cur_secure = 1'b1; #1;
    chk("R9 reset secure copy", dbg_ctx, RS);
    chk("R1 idle hit", {31'd0, acc_hit}, 32'd0);
    cur_secure = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 reset values read at level 3
    l3_access(1'b0, 1'b0, 32'h0);
    l3_access(1'b0, 1'b1, 32'h0);

    // Sweep of privilege, direction and control bits
    for (int idx = 0; idx < 2048; idx++) begin
      logic wr, e2, t13, trd, twr, trap_e, undef_e, grant_e, sel_s;
      logic [31:0] d, old_view;
      string tag;
      @(negedge clk);
      wr = idx[2]; e2 = idx[3]; t13 = idx[5]; trd = idx[6]; twr = idx[7];
      d = {idx[15:0] ^ 16'h3C5A, ~idx[15:0]};
      set_tuple(4'd15, 3'd0, 4'd13, 4'd0, 3'd1);
      acc_valid = 1'b1; acc_priv = idx[1:0]; acc_write = wr; acc_wdata = d;
      el2_enabled = e2; el2_is_32bit = idx[4];
      hyp_trap_crn13 = t13; hyp_trap_vm_rd = trd; hyp_trap_vm_wr = twr;
      mon_ns_bit = idx[8]; el3_present = idx[9]; el3_is_32bit = idx[10];
      cur_secure = 1'b0;
      undef_e = (idx[1:0] == 2'd0);
      trap_e  = (idx[1:0] == 2'd1) && e2 && (t13 || (wr ? twr : trd));
      grant_e = !undef_e && !trap_e;
      sel_s   = (idx[1:0] == 2'd3) && !idx[8];
      if (undef_e) tag = "R2";
      else if ((idx[1:0] == 2'd1) && e2 && t13) tag = "R3";
      else if ((idx[1:0] == 2'd1) && e2) tag = "R4";
      else if (idx[1:0] == 2'd3) tag = "R7";
      else tag = "R6";
      #2;
      chk({tag, " hit"}, {31'd0, acc_hit}, 32'd1);
      chk({tag, " undef"}, {31'd0, acc_undef}, {31'd0, undef_e});
      chk({tag, " trap"}, {31'd0, acc_trap}, {31'd0, trap_e});
      chk("R5 trap state flag", {31'd0, acc_trap_el2_32}, {31'd0, trap_e && idx[4]});
      chk("R3 syndrome", {26'd0, acc_syndrome}, trap_e ? 32'h3 : 32'h0);
      chk("R8 read data", acc_rdata, (grant_e && !wr) ? (sel_s ? m_s : m_ns) : 32'h0);
      old_view = view_exp(1'b0);
      chk("R8 no early write", dbg_ctx, old_view);
      @(posedge clk);
      if (grant_e && wr) begin
        if (sel_s) m_s = d; else m_ns = d;
      end
      #2;
      acc_valid = 1'b0;
      chk("R10 view non-secure state", dbg_ctx, view_exp(1'b0));
      cur_secure = 1'b1; #1;
      chk("R10 view secure state", dbg_ctx, view_exp(1'b1));
    end

    // R1 each tuple field off by one, write attempted at level 3
    el3_present = 1; el3_is_32bit = 1; cur_secure = 0;
    for (int f = 0; f < 5; f++) begin
      @(negedge clk);
      set_tuple(4'd15, 3'd0, 4'd13, 4'd0, 3'd1);
      case (f)
        0: acc_coproc = 4'd14;
        1: acc_opc1 = 3'd1;
        2: acc_crn = 4'd12;
        3: acc_crm = 4'd1;
        default: acc_opc2 = 3'd0;
      endcase
      acc_valid = 1; acc_write = 1; acc_priv = 2'd3; mon_ns_bit = 1; acc_wdata = 32'hDEAD_0000 + f;
      #2;
      chk("R1 miss hit", {31'd0, acc_hit}, 32'd0);
      chk("R1 miss flags", {30'd0, acc_undef, acc_trap}, 32'd0);
      @(posedge clk);
      #2 acc_valid = 0;
      chk("R1 miss no write", dbg_ctx, m_ns);
    end

    // R11 field split in both formats
    l3_access(1'b1, 1'b1, 32'hCAFE_B0A7);
    @(negedge clk);
    cur_secure = 0; long_desc_mode = 0; #1;
    chk("R11 short proc id", dbg_proc_id, 32'h00CA_FEB0);
    chk("R11 short asid", {24'd0, dbg_asid}, 32'hA7);
    chk("R11 short asid valid", {31'd0, dbg_asid_valid}, 32'd1);
    long_desc_mode = 1; #1;
    chk("R11 long proc id", dbg_proc_id, 32'hCAFE_B0A7);
    chk("R11 long asid", {24'd0, dbg_asid}, 32'h0);
    chk("R11 long asid valid", {31'd0, dbg_asid_valid}, 32'd0);
    long_desc_mode = 0;

    // R7 secure write then read back both copies
    l3_access(1'b1, 1'b0, 32'h1234_5678);
    l3_access(1'b0, 1'b0, 32'h0);
    l3_access(1'b0, 1'b1, 32'h0);

    report();
    $finish;
  end

endmodule